// File: doc/BRIEF.md
# Guardband Late-Transition Aging Monitor

This block sits beside the data input of a capture flip-flop at the end of a timing-critical path. It watches the path output during a guardband window that closes at the capture edge. If the path output still changes inside that window, the path has slowed down with wear, and the monitor raises an alarm. The alarm gives early warning, so that in-field compensation can act before the flip-flop captures a wrong value.

The monitor is modelled synchronously. An oversampling clock samples the path output, and a window-control input is high for the guardband interval. The alarm is a two-wire self-checking pair. Complementary values (01 or 10) mean healthy. Equal values (00 or 11) mean a late change was seen. A stuck or shorted pair wire therefore also reads as an alarm. A sticky flag keeps any alarm until it is cleared. A saturating counter records how many windows have alarmed.

A three-state machine tracks the window:
- `ST_IDLE` means the window is closed.
- `ST_WATCH` means the window is open and no late change has been seen.
- `ST_LATE` means a late change was seen in the current window.

Its transitions are:
- open: `ST_IDLE`→`ST_WATCH` when `win_i`=1.
- late: `ST_WATCH`→`ST_LATE` on a detected change.
- quiet close: `ST_WATCH`→`ST_IDLE` when `win_i`=0.
- alarm close: `ST_LATE`→`ST_IDLE` when `win_i`=0.

Top module: `aging_guard_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the monitor resets synchronously: after that edge `o1_o`=0, `o2_o`=1, `alarm_sticky_o`=0 and `alarm_cnt_o`=0.
- R2: With no alarm active, after each edge `o1_o` equals the `data_i` value sampled at that edge and `o2_o` is its inverse.
- R3: A late change is detected when `win_i` is 1 at two consecutive edges and `data_i` differs between them. From that edge onward, `o2_o` equals `o1_o`. This holds until the first edge at which `win_i` is sampled 0, and after that edge the pair is complementary again.
- R4: A change of `data_i` at the edge where `win_i` is first sampled 1 is not a late change. The previous sample is taken at that edge.
- R5: While an alarm is held, `o1_o` keeps tracking the sampled data, and further changes in the same window raise no second detection.
- R6: `alarm_sticky_o` goes to 1 at the edge that detects a late change. It stays 1 until an edge with `clr_i`=1 and no new detection. A detection at the same edge as `clr_i`=1 leaves the flag at 1.
- R7: `alarm_cnt_o` rises by exactly one for each window that alarms, and it stays at 2^CNT_W-1 once it gets there.
- R8: A window in which `data_i` stays constant keeps the pair complementary and leaves the flag and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_i | input | 1 | Monitored path output |
| win_i | input | 1 | Guardband window, 1 while open |
| clr_i | input | 1 | Synchronous clear of the sticky alarm flag |
| o1_o | output | 1 | Alarm pair wire 1 (sampled data) |
| o2_o | output | 1 | Alarm pair wire 2 (inverse, or a copy of wire 1 on alarm) |
| alarm_sticky_o | output | 1 | Sticky alarm flag |
| alarm_cnt_o | output | CNT_W | Saturating count of alarmed windows |

## Verification
Suppose the state machine wrongly sits in `ST_LATE`, or fails to leave it. The pair then shows equal values one edge too early, or stays equal after the window has closed, and a per-cycle compare catches this at once. Suppose instead the previous-sample register is stale when the window opens. A false alarm then appears at the edge after the opening, together with a flag and a counter step. A counter that wraps instead of saturating shows up at the first alarmed window after the maximum.

// File: rtl/amon_pkg.sv
package amon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_LATE  = 2'd2
    } amon_state_e;
endpackage

// File: rtl/amon_sampler.sv
module amon_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    output logic diff_o
);
    logic samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= data_i;
    end

    // the current input differs from the value held since the last edge
    assign diff_o = data_i ^ samp_q;
endmodule

// File: rtl/amon_fsm.sv
module amon_fsm
    import amon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic win_i,
    input  logic diff_i,
    output logic det_o,
    output logic o1_o,
    output logic o2_o
);
    amon_state_e state_q, state_d;

    // a change only counts when the window was already open at the previous edge
    assign det_o = (state_q == ST_WATCH) && win_i && diff_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_i) state_d = ST_WATCH;
            ST_WATCH: begin
                if (!win_i)     state_d = ST_IDLE;
                else if (det_o) state_d = ST_LATE;
            end
            ST_LATE:  if (!win_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o1_o <= 1'b0;
            o2_o <= 1'b1;
        end else begin
            o1_o <= data_i;
            o2_o <= (state_d == ST_LATE) ? data_i : ~data_i;
        end
    end
endmodule

// File: rtl/amon_tally.sv
module amon_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    input  logic             clr_i,
    output logic             sticky_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_o <= 1'b0;
            cnt_o    <= '0;
        end else begin
            sticky_o <= det_i | (sticky_o & ~clr_i);
            if (det_i && (cnt_o != CNT_MAX))
                cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/aging_guard_monitor.sv
module aging_guard_monitor #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_i,
    input  logic             win_i,
    input  logic             clr_i,
    output logic             o1_o,
    output logic             o2_o,
    output logic             alarm_sticky_o,
    output logic [CNT_W-1:0] alarm_cnt_o
);
    logic diff;
    logic det;

    amon_sampler u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (data_i),
        .diff_o (diff)
    );

    amon_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (data_i),
        .win_i  (win_i),
        .diff_i (diff),
        .det_o  (det),
        .o1_o   (o1_o),
        .o2_o   (o2_o)
    );

    amon_tally #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_i    (det),
        .clr_i    (clr_i),
        .sticky_o (alarm_sticky_o),
        .cnt_o    (alarm_cnt_o)
    );
endmodule

// File: rtl/aging_guard_monitor_chk.sv
module aging_guard_monitor_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_i,
    input logic             clr_i,
    input logic             o1_o,
    input logic             o2_o,
    input logic             alarm_sticky_o,
    input logic [CNT_W-1:0] alarm_cnt_o
);
    p_reset_pair_r1: assert property (@(posedge clk)
        !rst_n |=> (!o1_o && o2_o && !alarm_sticky_o && alarm_cnt_o == '0));

    p_closed_comp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> (o1_o != o2_o));

    p_new_alarm_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((o1_o == o2_o) && !$past(o1_o == o2_o)) |-> alarm_sticky_o);

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_sticky_o && !clr_i) |=> alarm_sticky_o);

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (alarm_cnt_o == $past(alarm_cnt_o)
                   || alarm_cnt_o == $past(alarm_cnt_o) + 1'b1));

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&alarm_cnt_o) |=> (&alarm_cnt_o));
endmodule

bind aging_guard_monitor aging_guard_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .win_i          (win_i),
    .clr_i          (clr_i),
    .o1_o           (o1_o),
    .o2_o           (o2_o),
    .alarm_sticky_o (alarm_sticky_o),
    .alarm_cnt_o    (alarm_cnt_o)
);

// File: tb/aging_guard_monitor_tb_top.sv
module aging_guard_monitor_tb_top;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data = 1'b0, win = 1'b0, clr = 1'b0;
    logic o1, o2, sticky;
    logic [CNT_W-1:0] cnt;

    int n_chk = 0, n_fail = 0;

    // bench model state
    logic m_samp, m_watch, m_late, m_stk, m_o1, m_o2;
    int   m_cnt;

    always #4 clk = ~clk;

    aging_guard_monitor #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .data_i(data), .win_i(win), .clr_i(clr),
        .o1_o(o1), .o2_o(o2), .alarm_sticky_o(sticky), .alarm_cnt_o(cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v == CMAX) ? v : v + 1;
    endfunction

    task automatic compare_all();
        chk("R2,R3,R5 o1", int'(o1), int'(m_o1));
        chk("R2,R3,R5 o2", int'(o2), int'(m_o2));
        chk("R6 sticky", int'(sticky), int'(m_stk));
        chk("R7 count", int'(cnt), m_cnt);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; data = 1'b0; win = 1'b0; clr = 1'b0;
        repeat (2) @(posedge clk);
        m_samp = 0; m_watch = 0; m_late = 0; m_stk = 0; m_o1 = 0; m_o2 = 1; m_cnt = 0;
        #2;
        chk("R1 o1", int'(o1), 0);
        chk("R1 o2", int'(o2), 1);
        chk("R1 sticky", int'(sticky), 0);
        chk("R1 count", int'(cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic d, input logic w, input logic c);
        logic det, late_n;
        @(negedge clk);
        data = d; win = w; clr = c;
        @(posedge clk);
        det    = w && m_watch && (d != m_samp);
        late_n = w && (m_late || det);
        if (det) m_cnt = sat_inc(m_cnt);
        m_stk   = det | (m_stk & ~c);
        m_late  = late_n;
        m_watch = w && !late_n;
        m_samp  = d;
        m_o1    = d;
        m_o2    = late_n ? d : ~d;
        #2;
        compare_all();
    endtask

    // one window that alarms: open, change inside, close
    task automatic alarm_window();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        do_reset();

        // R2: closed window, data toggling
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R2 complementary while closed", int'(o1 != o2), 1);

        // R4: change exactly at opening edge is not an alarm
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        chk("R4 opening edge no alarm", int'(o1 != o2), 1);
        chk("R4 count unchanged", int'(cnt), 0);

        // R8: quiet window
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R8 quiet window flag", int'(sticky), 0);

        // R3/R5: late change, further changes, close
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk("R3 pair equal after late change", int'(o1 == o2), 1);
        step(1'b1, 1'b1, 1'b0);
        chk("R5 o1 tracks data under alarm", int'(o1), 1);
        chk("R5 second change not counted", int'(cnt), 1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R3 pair complementary after close", int'(o1 != o2), 1);

        // R6: sticky hold, clear, clear versus new detection
        step(1'b0, 1'b0, 1'b0);
        chk("R6 sticky held", int'(sticky), 1);
        step(1'b0, 1'b0, 1'b1);
        chk("R6 sticky cleared", int'(sticky), 0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk("R6 detection wins over clear", int'(sticky), 1);
        step(1'b1, 1'b0, 1'b0);

        // R7: saturation
        for (int k = 0; k < 18; k++) alarm_window();
        chk("R7 count saturated", int'(cnt), CMAX);

        // mid-run reset, then random traffic
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            logic d, w, c;
            d = ($urandom_range(0, 3) == 0) ? ~data : data;
            w = ($urandom_range(0, 4) == 0) ? ~win : win;
            c = ($urandom_range(0, 15) == 0);
            step(d, w, c);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule